// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block forms 32-bit linear addresses from a 16-bit segment selector and a 32-bit offset. Software first programs the base and byte limit of a global and a local descriptor table through a small configuration port. Loading a selector starts a descriptor fetch. The block checks that the whole 8-byte entry lies inside the chosen table. It then reads the entry as two 32-bit words over a request/valid memory read port and unpacks it into a hidden cache: base, limit, granularity, default-size bit and access byte. It also keeps the requested privilege level of the selector.

Once the cache is filled, each translation request is served from the cache alone, with no memory traffic. The block adds the cached base to the offset and compares the offset against the effective segment limit. When the granularity bit is set, the effective limit is the 20-bit limit scaled to 4 KB units with the low 12 bits filled with ones. A translation that fails the check returns a limit fault and a zero address instead of a sum.

Top module: `seg_xlate`

## Requirements
- R1: After reset the cache is invalid, `ld_busy`, `ld_done`, `mem_req` and `out_valid` are low, and `cur_rpl` is 0.
- R2: The selector is split into an index in bits 15:3, a table select in bit 2 (0 global, 1 local) and a requested level in bits 1:0. After a successful load, `cur_rpl` equals selector bits 1:0.
- R3: The descriptor fetch reads address `table_base + index*8` first and then that address plus 4. `mem_addr` is held stable while `mem_req` waits for `mem_rvalid`.
- R4: If `index*8 + 7` is greater than the selected table limit, the load ends with `ld_done` and `ld_fault` high in the cycle after acceptance. No memory read is issued and the cache is unchanged.
- R5: Cached fields are unpacked from the words. Word0 is the first word and word1 the second. Base is {word1[31:24], word1[7:0], word0[31:16]}. Limit is {word1[19:16], word0[15:0]}. Access byte is word1[15:8]. Default-size is word1[22]. Granularity is word1[23]. Access byte and default-size appear on `cur_access` and `cur_dsize`.
- R6: With granularity 0 the effective limit is the 20-bit limit. With granularity 1 it is the limit shifted left by 12 with 12'hFFF in the low bits.
- R7: A translation request sampled at a clock edge produces `out_valid` in the next cycle, with `out_lin` equal to cached base plus offset modulo 2^32.
- R8: An offset greater than the effective limit gives `out_fault` = 1 and `out_lin` = 0. An offset equal to the limit is accepted.
- R9: A translation requested before any successful load returns `out_fault` = 1.
- R10: A translation sampled before the edge that writes the cache uses the old cache. A translation sampled while `ld_done` is high already uses the new one.
- R11: `ld_valid` is ignored while `ld_busy` is high. The running fetch keeps its selector and addresses.
- R12: A configuration write with `cfg_tsel` = 0 sets the global table base and limit, and with `cfg_tsel` = 1 sets the local table's. Later loads use the table named by selector bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a table register |
| cfg_tsel | input | 1 | Table written: 0 global, 1 local |
| cfg_base | input | 32 | Table base address |
| cfg_limit | input | TLIM_W | Table byte limit |
| ld_valid | input | 1 | Selector load request |
| ld_sel | input | 16 | Selector to load |
| ld_busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | One-cycle pulse when a load ends |
| ld_fault | output | 1 | With ld_done: the load failed the table limit check |
| mem_req | output | 1 | Memory read request, held until mem_rvalid |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Read data valid, completes the current request |
| mem_rdata | input | 32 | Read data word |
| xl_valid | input | 1 | Translation request |
| xl_offset | input | 32 | Offset to translate |
| out_valid | output | 1 | Translation result valid |
| out_lin | output | 32 | Linear address (0 on fault) |
| out_fault | output | 1 | Limit or empty-cache fault |
| cache_valid | output | 1 | Cache holds a loaded descriptor |
| cur_rpl | output | 2 | Requested level of the loaded selector |
| cur_access | output | 8 | Cached access byte |
| cur_dsize | output | 1 | Cached default-size bit |

## Verification
A translation and the end of a selector load can fall in the same cycle. The second descriptor word arrives at the same edge that samples a translation request, and the cache is written at that edge. The bench provokes this by asking for a translation in every cycle of every load, while the memory model answers after a random delay of zero to two cycles. Each translation result is judged against a model cache that the bench replaces only once it has seen `ld_done`. A result from the edge that wrote the cache must still reflect the old descriptor, and the next one must reflect the new descriptor.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   localparam int SEL_W   = 16;
   localparam int IDX_W   = 13;
   localparam int WORD_W  = 32;
   localparam int DLIM_W  = 20;
   localparam int ENTRY_SHIFT = 3;

   typedef struct packed {
      logic [WORD_W-1:0] base;
      logic [DLIM_W-1:0] limit;
      logic              gran;
      logic              dsize;
      logic [7:0]        access;
   } seg_desc_t;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_LO   = 2'd1,
      FS_HI   = 2'd2
   } fetch_state_t;

   function automatic seg_desc_t unpack_desc(input logic [WORD_W-1:0] lo,
                                             input logic [WORD_W-1:0] hi);
      seg_desc_t d;
      d.base   = {hi[31:24], hi[7:0], lo[31:16]};
      d.limit  = {hi[19:16], lo[15:0]};
      d.gran   = hi[23];
      d.dsize  = hi[22];
      d.access = hi[15:8];
      return d;
   endfunction

endpackage

// File: rtl/seg_tbl_regs.sv
module seg_tbl_regs #(
   parameter int TLIM_W = 16,
   parameter int N_TBL  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [$clog2(N_TBL)-1:0]  cfg_tsel,
   input  logic [31:0]               cfg_base,
   input  logic [TLIM_W-1:0]         cfg_limit,
   input  logic [$clog2(N_TBL)-1:0]  rd_tsel,
   output logic [31:0]               rd_base,
   output logic [TLIM_W-1:0]         rd_limit
);

   logic [31:0]       base_q  [N_TBL];
   logic [TLIM_W-1:0] limit_q [N_TBL];

   for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q[t]  <= '0;
            limit_q[t] <= '0;
         end else if (cfg_we && (cfg_tsel == t)) begin
            base_q[t]  <= cfg_base;
            limit_q[t] <= cfg_limit;
         end
      end
   end

   assign rd_base  = base_q[rd_tsel];
   assign rd_limit = limit_q[rd_tsel];

endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
   import seg_xlate_pkg::*;
#(
   parameter int TLIM_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [SEL_W-1:0]  ld_sel,
   input  logic [31:0]       tbl_base,
   input  logic [TLIM_W-1:0] tbl_limit,
   output logic              mem_req,
   output logic [31:0]       mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic              wr_en,
   output seg_desc_t         wr_desc,
   output logic [1:0]        wr_rpl
);

   localparam int OFS_W = IDX_W + ENTRY_SHIFT;

   fetch_state_t      state_q;
   logic [31:0]       addr_q;
   logic [31:0]       lo_q;
   logic [1:0]        rpl_q;
   logic              done_q;
   logic              fault_q;

   logic [OFS_W-1:0]  ent_ofs;
   logic [OFS_W-1:0]  ent_last;
   logic              over_lim;
   logic              accept;

   assign ent_ofs  = {ld_sel[SEL_W-1 -: IDX_W], {ENTRY_SHIFT{1'b0}}};
   assign ent_last = {ld_sel[SEL_W-1 -: IDX_W], {ENTRY_SHIFT{1'b1}}};
   assign over_lim = 32'(ent_last) > 32'(tbl_limit);
   assign accept   = (state_q == FS_IDLE) && ld_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         addr_q  <= '0;
         lo_q    <= '0;
         rpl_q   <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         unique case (state_q)
            FS_IDLE: begin
               if (accept) begin
                  if (over_lim) begin
                     done_q  <= 1'b1;
                     fault_q <= 1'b1;
                  end else begin
                     addr_q  <= tbl_base + 32'(ent_ofs);
                     rpl_q   <= ld_sel[1:0];
                     state_q <= FS_LO;
                  end
               end
            end
            FS_LO: begin
               if (mem_rvalid) begin
                  lo_q    <= mem_rdata;
                  addr_q  <= addr_q + 32'd4;
                  state_q <= FS_HI;
               end
            end
            FS_HI: begin
               if (mem_rvalid) begin
                  done_q  <= 1'b1;
                  state_q <= FS_IDLE;
               end
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != FS_IDLE);
   assign mem_req  = busy;
   assign mem_addr = addr_q;
   assign done     = done_q;
   assign fault    = fault_q;
   assign wr_en    = (state_q == FS_HI) && mem_rvalid;
   assign wr_desc  = unpack_desc(lo_q, mem_rdata);
   assign wr_rpl   = rpl_q;

endmodule

// File: rtl/seg_cache_xlate.sv
module seg_cache_xlate
   import seg_xlate_pkg::*;
#(
   parameter int GRAN_SHIFT    = 12,
   parameter bit PRECOMP_LIMIT = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  seg_desc_t   wr_desc,
   input  logic [1:0]  wr_rpl,
   input  logic        xl_valid,
   input  logic [31:0] xl_offset,
   output logic        out_valid,
   output logic [31:0] out_lin,
   output logic        out_fault,
   output logic        cache_valid,
   output logic [1:0]  cur_rpl,
   output logic [7:0]  cur_access,
   output logic        cur_dsize
);

   localparam logic [31:0] FILL_ONES = (32'd1 << GRAN_SHIFT) - 32'd1;

   seg_desc_t   cache_q;
   logic        valid_q;
   logic [1:0]  rpl_q;
   logic [31:0] eff_lim;
   logic [31:0] sum;
   logic        bad;
   logic        ov_q;
   logic [31:0] lin_q;
   logic        flt_q;

   function automatic logic [31:0] scale_lim(input logic [DLIM_W-1:0] lim,
                                             input logic g);
      logic [31:0] z;
      z = 32'(lim);
      return g ? ((z << GRAN_SHIFT) | FILL_ONES) : z;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cache_q <= '0;
         valid_q <= 1'b0;
         rpl_q   <= '0;
      end else if (wr_en) begin
         cache_q <= wr_desc;
         valid_q <= 1'b1;
         rpl_q   <= wr_rpl;
      end
   end

   if (PRECOMP_LIMIT) begin : g_pre
      logic [31:0] eff_q;
      always_ff @(posedge clk) begin
         if (!rst_n)     eff_q <= '0;
         else if (wr_en) eff_q <= scale_lim(wr_desc.limit, wr_desc.gran);
      end
      assign eff_lim = eff_q;
   end else begin : g_late
      assign eff_lim = scale_lim(cache_q.limit, cache_q.gran);
   end

   assign sum = cache_q.base + xl_offset;
   assign bad = !valid_q || (xl_offset > eff_lim);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ov_q  <= 1'b0;
         lin_q <= '0;
         flt_q <= 1'b0;
      end else begin
         ov_q <= xl_valid;
         if (xl_valid) begin
            lin_q <= bad ? 32'd0 : sum;
            flt_q <= bad;
         end
      end
   end

   assign out_valid   = ov_q;
   assign out_lin     = lin_q;
   assign out_fault   = flt_q;
   assign cache_valid = valid_q;
   assign cur_rpl     = rpl_q;
   assign cur_access  = cache_q.access;
   assign cur_dsize   = cache_q.dsize;

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int TLIM_W        = 16,
   parameter int GRAN_SHIFT    = 12,
   parameter bit PRECOMP_LIMIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_tsel,
   input  logic [31:0]       cfg_base,
   input  logic [TLIM_W-1:0] cfg_limit,
   input  logic              ld_valid,
   input  logic [15:0]       ld_sel,
   output logic              ld_busy,
   output logic              ld_done,
   output logic              ld_fault,
   output logic              mem_req,
   output logic [31:0]       mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   input  logic              xl_valid,
   input  logic [31:0]       xl_offset,
   output logic              out_valid,
   output logic [31:0]       out_lin,
   output logic              out_fault,
   output logic              cache_valid,
   output logic [1:0]        cur_rpl,
   output logic [7:0]        cur_access,
   output logic              cur_dsize
);

   localparam int TI_BIT = SEL_W - IDX_W - 1;

   if (TLIM_W < ENTRY_SHIFT || TLIM_W > 32) begin : g_bad_tlim
      initial $fatal(1, "seg_xlate: TLIM_W out of range");
   end
   if (GRAN_SHIFT < 1 || GRAN_SHIFT + DLIM_W > 32) begin : g_bad_gran
      initial $fatal(1, "seg_xlate: GRAN_SHIFT out of range");
   end

   logic [31:0]       tbl_base;
   logic [TLIM_W-1:0] tbl_limit;
   logic              wr_en;
   seg_desc_t         wr_desc;
   logic [1:0]        wr_rpl;

   seg_tbl_regs #(.TLIM_W(TLIM_W), .N_TBL(2)) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_tsel  (cfg_tsel),
      .cfg_base  (cfg_base),
      .cfg_limit (cfg_limit),
      .rd_tsel   (ld_sel[TI_BIT]),
      .rd_base   (tbl_base),
      .rd_limit  (tbl_limit)
   );

   seg_desc_fetch #(.TLIM_W(TLIM_W)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_valid   (ld_valid),
      .ld_sel     (ld_sel),
      .tbl_base   (tbl_base),
      .tbl_limit  (tbl_limit),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .busy       (ld_busy),
      .done       (ld_done),
      .fault      (ld_fault),
      .wr_en      (wr_en),
      .wr_desc    (wr_desc),
      .wr_rpl     (wr_rpl)
   );

   seg_cache_xlate #(.GRAN_SHIFT(GRAN_SHIFT), .PRECOMP_LIMIT(PRECOMP_LIMIT)) u_cache (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_desc     (wr_desc),
      .wr_rpl      (wr_rpl),
      .xl_valid    (xl_valid),
      .xl_offset   (xl_offset),
      .out_valid   (out_valid),
      .out_lin     (out_lin),
      .out_fault   (out_fault),
      .cache_valid (cache_valid),
      .cur_rpl     (cur_rpl),
      .cur_access  (cur_access),
      .cur_dsize   (cur_dsize)
   );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ld_busy,
   input logic        ld_done,
   input logic        ld_fault,
   input logic        mem_req,
   input logic [31:0] mem_addr,
   input logic        mem_rvalid,
   input logic        xl_valid,
   input logic        out_valid,
   input logic        out_fault,
   input logic [31:0] out_lin,
   input logic        cache_valid,
   input logic [1:0]  cur_rpl
);

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   assert_fault_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ld_fault |-> (ld_done && !mem_req));

   assert_result_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
      xl_valid |=> out_valid);

   assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !xl_valid |=> !out_valid);

   assert_fault_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_fault) |-> (out_lin == 32'd0));

   assert_cold_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !cache_valid) |-> out_fault);

   assert_cache_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_rpl != $past(cur_rpl)) |-> (ld_done && !ld_fault));

   assert_req_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ld_busy);

   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ld_done |-> !ld_busy);

endmodule

bind seg_xlate seg_xlate_chk u_chk (.*);

// File: tb/seg_xlate_test.sv
module seg_xlate_test;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] GBASE = 32'h0010_0000;
   localparam logic [31:0] LBASE = 32'h0800_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_tsel = 1'b0;
   logic [31:0] cfg_base = '0;
   logic [15:0] cfg_limit = '0;
   logic        ld_valid = 1'b0;
   logic [15:0] ld_sel = '0;
   logic        ld_busy, ld_done, ld_fault, mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        xl_valid = 1'b0;
   logic [31:0] xl_offset = '0;
   logic        out_valid, out_fault, cache_valid, cur_dsize;
   logic [31:0] out_lin;
   logic [1:0]  cur_rpl;
   logic [7:0]  cur_access;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // table models
   logic [31:0] g_base = '0, l_base = '0;
   logic [15:0] g_lim = '0, l_lim = '0;
   // cache model
   bit          m_valid = 0;
   logic [31:0] m_base = '0, m_eff = '0;
   logic [1:0]  m_rpl = '0;
   logic [7:0]  m_acc = '0;
   logic        m_d = 1'b0;
   // memory model log
   int          acc_n = 0;
   logic [31:0] acc_log [2];
   int          dly = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   seg_xlate uut (.*);

   function automatic logic [31:0] mword(input logic [31:0] a);
      logic [31:0] x;
      case (a)
         32'h0010_0028: return 32'h0000_01FF;
         32'h0010_002C: return 32'h1040_9200;
         32'h0010_0030: return 32'h0000_01FF;
         32'h0010_0034: return 32'h10C0_9200;
         default: begin
            x = a * 32'h9E37_79B1;
            return x ^ (x >> 15) ^ 32'h5BD1_E995;
         end
      endcase
   endfunction

   always @(negedge clk) begin
      if (mem_rvalid) mem_rvalid <= 1'b0;
      else if (mem_req) begin
         if (dly == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mword(mem_addr);
            if (acc_n < 2) acc_log[acc_n] = mem_addr;
            acc_n = acc_n + 1;
            dly = $urandom % 3;
         end else dly = dly - 1;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pick_off();
      case ($urandom % 5)
         0: return 32'd0;
         1: return m_eff;
         2: return m_eff + 32'd1;
         3: return $urandom & m_eff;
         default: return $urandom;
      endcase
   endfunction

   function automatic logic [32:0] exp_xl(input logic [31:0] off);
      if (!m_valid || off > m_eff) return {1'b1, 32'd0};
      return {1'b0, m_base + off};
   endfunction

   task automatic cfg_write(input logic t, input logic [31:0] b, input logic [15:0] l);
      cfg_we = 1; cfg_tsel = t; cfg_base = b; cfg_limit = l;
      @(negedge clk);
      cfg_we = 0;
      if (t) begin l_base = b; l_lim = l; end
      else   begin g_base = b; g_lim = l; end
   endtask

   task automatic xl_check(input logic [31:0] off, input string req);
      logic [32:0] e;
      e = exp_xl(off);
      xl_valid = 1; xl_offset = off;
      @(negedge clk);
      xl_valid = 0;
      chk({req, " valid"}, 64'(out_valid), 64'd1);
      chk({req, " fault"}, 64'(out_fault), 64'(e[32]));
      chk({req, " lin"}, 64'(out_lin), 64'(e[31:0]));
   endtask

   // load a selector while translating every cycle (R10) and re-driving ld_valid while busy (R11)
   task automatic run_load(input logic [15:0] sel);
      logic [31:0] tb, ea, w0, w1, lim20;
      logic [15:0] tl;
      logic        efault, done;
      logic [32:0] e;
      int          n;
      tb = sel[2] ? l_base : g_base;
      tl = sel[2] ? l_lim  : g_lim;
      efault = {sel[15:3], 3'b111} > tl;
      ea = tb + {16'h0, sel[15:3], 3'b000};
      acc_n = 0;
      ld_valid = 1; ld_sel = sel;
      xl_offset = pick_off(); e = exp_xl(xl_offset); xl_valid = 1;
      done = 0; n = 0;
      while (!done && n < 200) begin
         @(negedge clk); n++;
         chk("R10 fault during load", 64'(out_fault), 64'(e[32]));
         chk("R10 lin during load", 64'(out_lin), 64'(e[31:0]));
         if (ld_done) begin
            done = 1;
            chk("R4 load fault flag", 64'(ld_fault), 64'(efault));
            if (efault) begin
               chk("R4 no read on fault", 64'(acc_n), 64'd0);
            end else begin
               chk("R3 read count", 64'(acc_n), 64'd2);
               chk("R3 R12 first address", 64'(acc_log[0]), 64'(ea));
               chk("R3 second address", 64'(acc_log[1]), 64'(ea + 32'd4));
               w0 = mword(ea); w1 = mword(ea + 32'd4);
               m_valid = 1;
               m_base = {w1[31:24], w1[7:0], w0[31:16]};
               lim20 = {12'h0, w1[19:16], w0[15:0]};
               m_eff = w1[23] ? {lim20[19:0], 12'hFFF} : lim20;
               m_rpl = sel[1:0]; m_acc = w1[15:8]; m_d = w1[22];
            end
            chk("R2 requested level", 64'(cur_rpl), 64'(m_rpl));
            chk("R5 access byte", 64'(cur_access), 64'(m_acc));
            chk("R5 default size", 64'(cur_dsize), 64'(m_d));
            chk("R9 cache valid", 64'(cache_valid), 64'(m_valid));
         end
         ld_valid = ld_busy;
         ld_sel = ~sel;
         xl_offset = pick_off(); e = exp_xl(xl_offset);
      end
      ld_valid = 0;
      @(negedge clk);
      xl_valid = 0;
      chk("R10 first lookup after load", 64'(out_lin), 64'(e[31:0]));
      chk("R6 R8 fault after load", 64'(out_fault), 64'(e[32]));
      if (!done) chk("R11 load finished", 64'd0, 64'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 cache invalid", 64'(cache_valid), 64'd0);
      chk("R1 idle", 64'({ld_busy, ld_done, mem_req, out_valid}), 64'd0);
      chk("R1 rpl", 64'(cur_rpl), 64'd0);
      xl_check(32'd0, "R9 cold lookup");

      cfg_write(1'b0, GBASE, 16'hFFFF);
      cfg_write(1'b1, LBASE, 16'h01FF);

      // directed: base 10000000h, limit 1FFh, granularity 0 then 1
      run_load({13'd5, 1'b0, 2'd3});
      xl_check(32'h0000_01FF, "R6 R8 G0 at limit");
      xl_check(32'h0000_0200, "R8 G0 past limit");
      run_load({13'd6, 1'b0, 2'd1});
      xl_check(32'h001F_FFFF, "R6 G1 at limit");
      xl_check(32'h0020_0000, "R6 R8 G1 past limit");
      // local table edges (R12)
      run_load({13'd63, 1'b1, 2'd2});
      run_load({13'd64, 1'b1, 2'd0});
      xl_check(32'd0, "R4 cache kept");
      // tiny table: even entry 0 does not fit
      cfg_write(1'b1, LBASE, 16'h0006);
      run_load({13'd0, 1'b1, 2'd1});

      cfg_write(1'b1, 32'h7FFF_FFF0, 16'h0FFF);
      for (int i = 0; i < 60; i++) begin
         logic [15:0] s;
         s = $urandom;
         if (s[2]) s[15:3] = 13'($urandom % 530);
         run_load(s);
         for (int k = 0; k < 3; k++) xl_check(pick_off(), "R7 R8 random lookup");
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule